// File: doc/BRIEF.md
# Host-Strobed Parallel Configuration Byte Loader

This block is the front end that accepts configuration bytes from an external microprocessor. The host drives an 8-bit data bus and four write controls: three active-low selects and one active-high write strobe. A write is open only while all four controls are asserted together. The byte is taken when any one of the four drops out. The captured byte is then sent to a configuration-memory sink, one bit per clock, least significant bit first, with a valid strobe. A ready/busy output tells the host when the next byte may be written.

The controls and the data bus are brought into the system clock through a chain of synchronising flip-flops. The end of the write is found as a falling edge of the synchronised "all asserted" signal. Two status outputs report that configuration is still in progress: one is high-true and one is low-true. An end-of-configuration pulse is latched. Once the loader is idle, the pulse moves it into a final state. In that state the handshake and status outputs are released to fixed user-side levels, and further writes have no effect.

Three states make up the controller. `LD_IDLE` waits for a write. `LD_SHIFT` sends the captured byte. `LD_DONE` is terminal until reset. The transitions are:
- `LD_IDLE` goes to `LD_SHIFT` on a completed write when no end request is pending.
- `LD_SHIFT` goes back to `LD_IDLE` after the eighth bit.
- `LD_IDLE` goes to `LD_DONE` when an end request is pending. The end request takes priority over a write completing in the same cycle.

Top module: `cfg_parallel_loader`

## Requirements
- R1: After reset, `host_ready` = 1, `cfg_busy_hi` = 1, `cfg_busy_lo` = 0, `ser_valid` = 0 and `overrun` = 0.
- R2: A write is recognised only while `sel_n[2:0]` = 3'b000 and `wr_strobe` = 1 at the same time. Asserting any three of the four and then releasing them produces no serial output.
- R3: When any one of the four controls is released, the byte held on `host_data` while all four were asserted is captured. Bytes are delivered in the order they were written, each exactly once, whatever control is released first.
- R4: A captured byte appears on `ser_data` over exactly 8 consecutive cycles with `ser_valid` = 1, bit 0 first, then bit 1, up to bit 7.
- R5: `host_ready` is 0 in every cycle in which `ser_valid` is 1, and it returns to 1 once the eighth bit has been sent.
- R6: A write that completes while a byte is being sent is discarded: none of its bits is ever sent. It sets `overrun` to 1, and `overrun` stays 1 until reset. Later writes are accepted normally.
- R7: A one-cycle pulse on `cfg_end` is latched. Once the loader is idle it moves to the done state. From then until reset, `cfg_busy_hi` = 0, `cfg_busy_lo` = 1 and `host_ready` = 0.
- R8: In the done state, completed writes produce no serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 3 | Three active-low chip selects (asynchronous) |
| wr_strobe | input | 1 | Active-high write strobe (asynchronous) |
| host_data | input | 8 | Configuration byte from the host |
| cfg_end | input | 1 | End-of-configuration indication, synchronous pulse or level |
| host_ready | output | 1 | 1 = ready for the next byte, 0 = busy or released |
| cfg_busy_hi | output | 1 | High while configuration is in progress |
| cfg_busy_lo | output | 1 | Low while configuration is in progress |
| ser_data | output | 1 | Serial configuration bit, LSB first |
| ser_valid | output | 1 | Qualifies `ser_data` |
| overrun | output | 1 | Sticky flag: a write arrived while busy |

## Verification
The hardest case to reach from the ports is a write that completes while a byte is still being sent. It needs a second full assert-and-release cycle that lands inside the 8-cycle busy window, after the synchroniser delay. The stimulus reaches it by following a normal write at once with a short write in which all four controls are asserted together. It then checks that the second byte never appears on the serial output and that the overrun flag rises and stays high. The random writes vary which control is asserted first and which is released first, so the falling-edge detection is exercised through every control input.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SHIFT = 2'd1,
        LD_DONE  = 2'd2
    } ld_state_t;

    localparam int unsigned NUM_SEL = 3;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgl_shift.sv
module cfgl_shift #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          en,
    output logic          bit_out,
    output logic          last
);
    localparam int unsigned CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(DW - 1);

    logic [DW-1:0] sreg;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (load) begin
            sreg <= load_data;
            cnt  <= '0;
        end else if (en) begin
            sreg <= sreg >> 1;
            cnt  <= cnt + 1'b1;
        end
    end

    assign bit_out = sreg[0];
    assign last    = (cnt == LAST_IDX);

    AST_SHIFT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && last) |=> !en) else $error("shift ran past last bit"); // R4
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !en) else $error("load while shifting"); // R6
endmodule

// File: rtl/cfg_parallel_loader.sv
module cfg_parallel_loader #(
    parameter int unsigned DW          = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    sel_n,
    input  logic          wr_strobe,
    input  logic [DW-1:0] host_data,
    input  logic          cfg_end,
    output logic          host_ready,
    output logic          cfg_busy_hi,
    output logic          cfg_busy_lo,
    output logic          ser_data,
    output logic          ser_valid,
    output logic          overrun
);
    import cfgl_pkg::*;

    localparam int unsigned CTL_W = NUM_SEL + 1;
    localparam logic [CTL_W-1:0] CTL_IDLE = {1'b0, {NUM_SEL{1'b1}}};

    ld_state_t state, state_nx;

    logic [CTL_W-1:0] ctl_s;
    logic [DW-1:0]    data_s, data_q;
    logic             all_now, all_q, wr_fall;
    logic             end_req, load, shift_en, last;

    cfgl_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d({wr_strobe, sel_n}), .q(ctl_s)
    );

    cfgl_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d(host_data), .q(data_s)
    );

    assign all_now = ctl_s[CTL_W-1] & ~(|ctl_s[NUM_SEL-1:0]);
    assign wr_fall = all_q & ~all_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            all_q   <= 1'b0;
            data_q  <= '0;
            end_req <= 1'b0;
            overrun <= 1'b0;
        end else begin
            all_q  <= all_now;
            data_q <= data_s;
            if (cfg_end) end_req <= 1'b1;
            if (wr_fall && state == LD_SHIFT) overrun <= 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LD_IDLE: begin
                if (end_req)      state_nx = LD_DONE;
                else if (wr_fall) state_nx = LD_SHIFT;
            end
            LD_SHIFT: if (last)   state_nx = LD_IDLE;
            LD_DONE:              state_nx = LD_DONE;
            default:              state_nx = LD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        host_ready  = 1'b0;
        cfg_busy_hi = 1'b1;
        cfg_busy_lo = 1'b0;
        shift_en    = 1'b0;
        load        = 1'b0;
        unique case (state)
            LD_IDLE: begin
                host_ready = 1'b1;
                load       = wr_fall & ~end_req;
            end
            LD_SHIFT: shift_en = 1'b1;
            LD_DONE: begin
                cfg_busy_hi = 1'b0;
                cfg_busy_lo = 1'b1;
            end
            default: ;
        endcase
    end

    cfgl_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(data_q),
        .en(shift_en), .bit_out(ser_data), .last(last)
    );

    assign ser_valid = shift_en;

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun) else $error("overrun cleared"); // R6
    AST_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && wr_fall && !end_req) |=> (ser_valid && !host_ready)) else $error("write not taken"); // R3
    AST_DONE_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_busy_hi) |=> (!cfg_busy_hi && cfg_busy_lo && !host_ready)) else $error("done left"); // R7
    AST_NO_DATA_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_busy_hi) |-> !ser_valid) else $error("serial output after done"); // R8
endmodule

// File: tb/tb_cfg_parallel_loader.sv
module tb_cfg_parallel_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel_n = 3'b111;
    logic       wr_strobe = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       cfg_end = 1'b0;
    logic host_ready, cfg_busy_hi, cfg_busy_lo, ser_data, ser_valid, overrun;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q [64];
    int         exp_n = 0;
    logic [7:0] rx_q [64];
    int         rx_n = 0;
    logic [7:0] rx_sr;
    int         rx_bits = 0;

    always #5 clk = ~clk;

    cfg_parallel_loader dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_strobe(wr_strobe),
        .host_data(host_data), .cfg_end(cfg_end), .host_ready(host_ready),
        .cfg_busy_hi(cfg_busy_hi), .cfg_busy_lo(cfg_busy_lo),
        .ser_data(ser_data), .ser_valid(ser_valid), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [3:0] assert_mask(input logic [3:0] m);
        return m;
    endfunction

    // drive control index: 0..2 selects, 3 strobe
    task automatic set_ctl(input int idx, input bit on);
        if (idx == 3) wr_strobe = on;
        else          sel_n[idx] = ~on;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // full write: random assertion order, chosen control released first
    task automatic do_write(input logic [7:0] b, input int first_rel, input bit expect_out);
        int order [4];
        for (int i = 0; i < 4; i++) order[i] = i;
        for (int i = 3; i > 0; i--) begin
            int j = int'($urandom % (i + 1));
            int t = order[i]; order[i] = order[j]; order[j] = t;
        end
        host_data = b;
        for (int i = 0; i < 4; i++) begin
            set_ctl(order[i], 1'b1);
            cycles(1 + int'($urandom % 2));
        end
        cycles(3);
        set_ctl(first_rel, 1'b0);
        cycles(1);
        for (int i = 0; i < 4; i++) set_ctl(i, 1'b0);
        if (expect_out) begin
            exp_q[exp_n] = b;
            exp_n++;
        end
    endtask

    function automatic int bits_of(input logic [7:0] v);
        return int'(v);
    endfunction

    // serial monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (ser_valid) begin
                chk(!host_ready, "R5 ready low while sending", int'(host_ready), 0);
                rx_sr = {ser_data, rx_sr[7:1]};
                rx_bits++;
                if (rx_bits == 8) begin
                    rx_q[rx_n % 64] = rx_sr;
                    rx_n++;
                    rx_bits = 0;
                end
            end else if (rx_bits != 0) begin
                chk(1'b0, "R4 valid run shorter than 8", rx_bits, 8);
                rx_bits = 0;
            end
        end
    end

    task automatic finish_run;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        int rx_before;
        void'($urandom(32'd20417));
        cycles(3);
        // R1 reset state
        chk(host_ready == 1'b1, "R1 ready", int'(host_ready), 1);
        chk(cfg_busy_hi == 1'b1 && cfg_busy_lo == 1'b0, "R1 status", int'({cfg_busy_hi, cfg_busy_lo}), 2);
        chk(ser_valid == 1'b0 && overrun == 1'b0, "R1 valid/overrun", int'({ser_valid, overrun}), 0);
        rst_n = 1'b1;
        cycles(3);
        chk(host_ready == 1'b1, "R1 ready after release", int'(host_ready), 1);

        // R3 directed: each control released first
        for (int k = 0; k < 4; k++) begin
            do_write(8'hA0 + 8'(k * 17), k, 1'b1);
            cycles(14);
            chk(host_ready == 1'b1, "R5 ready returns", int'(host_ready), 1);
        end
        // corner bytes
        do_write(8'h00, 3, 1'b1); cycles(14);
        do_write(8'hFF, 0, 1'b1); cycles(14);
        do_write(8'h01, 2, 1'b1); cycles(14);
        do_write(8'h80, 1, 1'b1); cycles(14);

        // R2: three of four asserted only
        for (int k = 0; k < 4; k++) begin
            rx_before = rx_n;
            host_data = 8'h5A;
            for (int i = 0; i < 4; i++) if (i != k) set_ctl(i, 1'b1);
            cycles(5);
            for (int i = 0; i < 4; i++) set_ctl(i, 1'b0);
            cycles(14);
            chk(rx_n == rx_before, "R2 partial assert gives no byte", rx_n - rx_before, 0);
        end

        // random writes
        for (int n = 0; n < 20; n++) begin
            do_write(8'($urandom), int'($urandom % 4), 1'b1);
            cycles(12 + int'($urandom % 4));
        end
        chk(overrun == 1'b0, "R6 no overrun yet", int'(overrun), 0);

        // R6: write completing while busy
        do_write(8'h3C, 1, 1'b1);
        cycles(1);
        host_data = 8'hC3;
        for (int i = 0; i < 4; i++) set_ctl(i, 1'b1);
        cycles(2);
        for (int i = 0; i < 4; i++) set_ctl(i, 1'b0);
        cycles(16);
        chk(overrun == 1'b1, "R6 overrun set", int'(overrun), 1);
        do_write(8'h96, 3, 1'b1); cycles(14);
        chk(overrun == 1'b1, "R6 overrun sticky", int'(overrun), 1);

        // R3/R4: delivered sequence
        chk(rx_n == exp_n, "R3 byte count", rx_n, exp_n);
        for (int i = 0; i < exp_n && i < rx_n; i++)
            chk(rx_q[i] == exp_q[i], "R3 R4 byte order/value", bits_of(rx_q[i]), bits_of(exp_q[i]));

        // R7: end of configuration
        @(negedge clk) cfg_end = 1'b1;
        @(negedge clk) cfg_end = 1'b0;
        cycles(3);
        chk(cfg_busy_hi == 1'b0 && cfg_busy_lo == 1'b1, "R7 status released", int'({cfg_busy_hi, cfg_busy_lo}), 1);
        chk(host_ready == 1'b0, "R7 ready released", int'(host_ready), 0);

        // R8: writes after done
        rx_before = rx_n;
        do_write(8'h77, 0, 1'b0);
        cycles(16);
        chk(rx_n == rx_before, "R8 no output after done", rx_n - rx_before, 0);
        chk(cfg_busy_hi == 1'b0 && cfg_busy_lo == 1'b1 && host_ready == 1'b0, "R7 done persists",
            int'({cfg_busy_hi, cfg_busy_lo, host_ready}), 2);
        finish_run();
    end
endmodule